// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block stretches external bus cycles by a programmable number of wait states. It classifies each access by its space type (program, data or I/O) and by its address into one of five regions. Each region has its own 3-bit base count, and a global doubling bit can scale every count by two. When the software count runs out, an external ready input can hold the cycle open for as long as a slow device needs.

A 16-bit configuration register and a 1-bit multiplier register are written through a small register port. The bus master pulses a request together with the space and the address. The block drives `bus_wait` high for the programmed number of cycles, and then for as long as ready stays low. To save power, the clock enable of the wait counter drops whenever every region is programmed to zero and no count is pending.

Top module: `bus_wait_gen`

## Requirements
- R1: After reset the five count fields are 7, the extended-address select is 0 and the multiplier is 0, so every region inserts exactly 7 waits.
- R2: A write with `cfg_sel`=0 loads `cfg_wdata` into the configuration register. Bits 2:0 hold the lower program count, 5:3 the upper program count, 8:6 the lower data count, 11:9 the upper data count, 14:12 the I/O count, and bit 15 the extended-address select. A write with `cfg_sel`=1 loads the multiplier from `cfg_wdata[0]`.
- R3: The effective count is the base count times 1 when the multiplier is 0, and times 2 when it is 1. The largest value is 14.
- R4: Space code 2'b01 is data space: address bit 15 = 0 selects the lower data field and bit 15 = 1 selects the upper data field. Space codes 2'b10 and 2'b11 are I/O space and always use the I/O field, whatever the address.
- R5: Space code 2'b00 is program space. With the extended-address select at 0, address bit 15 picks the upper program field (1) or the lower one (0). With the select at 1, address bit 22 makes that choice instead.
- R6: The request cycle is cycle 0. For an effective count N > 0 with ready high, `bus_wait` is high in cycles 0 to N-1 and low in cycle N. Ready is ignored while the count is nonzero.
- R7: If ready is low in cycles 0 to L-1 and high afterwards, the access shows `bus_wait` high for exactly max(N, L) cycles.
- R8: An access with effective count 0 and ready high shows no `bus_wait` at all.
- R9: A configuration write during an access does not change the count already loaded. It applies only to the next request.
- R10: A request strobe that arrives while an access is in progress is ignored. The access in progress keeps its own length.
- R11: `cnt_clk_en` is low when all five count fields are 0 and no count is pending. It is high whenever any field is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = configuration register, 1 = multiplier bit |
| cfg_wdata | input | 16 | Write data |
| acc_req | input | 1 | Access request strobe, one cycle |
| acc_space | input | 2 | 00 program, 01 data, 1x I/O |
| acc_addr | input | 23 | Access address |
| acc_ready | input | 1 | External ready, high = device ready |
| bus_wait | output | 1 | High while the bus cycle must be stretched |
| cnt_clk_en | output | 1 | Clock enable of the wait counter |

## Verification
`bus_wait` responds in the same cycle as the request. Cycle 0 is decided combinationally from the request and the configuration, and later cycles follow the counter, which is loaded with N-1 at the edge that closes cycle 0. The bench therefore drives inputs on the falling edge and samples a quarter period later, counting the wait cycles until the first cycle with `bus_wait` low. It compares that count with N, or with max(N, L) when ready is held low, where N is the base count from the register model times the multiplier factor. `cnt_clk_en` is sampled in the cycle in which an access completes, and again after a register write has landed on the following rising edge.

// File: rtl/wsg_pkg.sv
// Package: shared constants and types of the wait-state generator.
// Assumes five regions whose 3-bit fields sit in order from bit 0 upward,
// with the extended-address select bit just above the last field.
package wsg_pkg;
    localparam int NUM_RGN   = 5;
    localparam int BASE_W    = 3;
    localparam int CNT_W     = BASE_W + 1;
    localparam int CFG_W     = NUM_RGN * BASE_W + 1;
    localparam int ADDR_W    = 23;
    localparam int SPLIT_BIT = 15;

    typedef enum logic [2:0] {
        RG_PROG_LO = 3'd0,
        RG_PROG_HI = 3'd1,
        RG_DATA_LO = 3'd2,
        RG_DATA_HI = 3'd3,
        RG_IO      = 3'd4
    } region_e;

    localparam logic [1:0] SP_PROG = 2'b00;
    localparam logic [1:0] SP_DATA = 2'b01;
endpackage

// File: rtl/wsg_cfg_regs.sv
// Module: configuration and multiplier registers.
// Holds the packed field register and the doubling bit; writes land on the
// rising edge where cfg_wr is high. Assumes a synchronous active-low reset.
module wsg_cfg_regs
    import wsg_pkg::*;
#(
    parameter int N_RGN  = NUM_RGN,
    parameter int FLD_W  = BASE_W,
    localparam int REG_W = N_RGN * FLD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg_q,
    output logic             mul_q
);
    localparam logic [REG_W-1:0] CFG_RST = {1'b0, {(REG_W-1){1'b1}}};

    // Field register: reset to maximum counts, loaded on a select-0 write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (wr && !sel) begin
            cfg_q <= wdata;
        end
    end

    // Multiplier bit: reset to factor 1, loaded from bit 0 on a select-1 write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mul_q <= 1'b0;
        end else if (wr && sel) begin
            mul_q <= wdata[0];
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && !sel) |=> $stable(cfg_q)); // R2
    AST_MUL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel) |=> $stable(mul_q)); // R2
endmodule

// File: rtl/wsg_region_map.sv
// Module: region classifier and effective-count calculation.
// Purely combinational. Splits the field register into per-region counts,
// picks one from the space code and address, and applies the multiplier.
// Assumes the address is at least SPLIT_BIT+1 bits wide.
module wsg_region_map
    import wsg_pkg::*;
#(
    parameter int A_W    = ADDR_W,
    parameter int N_RGN  = NUM_RGN,
    parameter int FLD_W  = BASE_W,
    localparam int REG_W = N_RGN * FLD_W + 1,
    localparam int EFF_W = FLD_W + 1
) (
    input  logic [1:0]       space,
    input  logic [A_W-1:0]   addr,
    input  logic [REG_W-1:0] cfg,
    input  logic             mul,
    output region_e          rgn,
    output logic [EFF_W-1:0] eff_cnt,
    output logic             any_nonzero
);
    logic [FLD_W-1:0] fld [N_RGN];
    logic [N_RGN-1:0] fld_nz;
    logic             xsel;
    logic             prog_hi;
    logic [FLD_W-1:0] base;
    logic             addr_unused;

    assign xsel        = cfg[REG_W-1];
    assign addr_unused = ^addr;

    // Unpack each region's field and flag it when nonzero.
    for (genvar r = 0; r < N_RGN; r++) begin : g_fld
        assign fld[r]    = cfg[r*FLD_W +: FLD_W];
        assign fld_nz[r] = |cfg[r*FLD_W +: FLD_W];
    end

    assign any_nonzero = |fld_nz;

    // Upper-program decision: bit 15 normally, the top address bit when extended.
    assign prog_hi = xsel ? addr[A_W-1] : addr[SPLIT_BIT];

    // Region select from the space code and address bits.
    always_comb begin
        if (space == SP_PROG) begin
            rgn = prog_hi ? RG_PROG_HI : RG_PROG_LO;
        end else if (space == SP_DATA) begin
            rgn = addr[SPLIT_BIT] ? RG_DATA_HI : RG_DATA_LO;
        end else begin
            rgn = RG_IO;
        end
    end

    // Base count of the chosen region, scaled by the multiplier.
    always_comb begin
        base    = fld[rgn];
        eff_cnt = mul ? {base, 1'b0} : {1'b0, base};
    end
endmodule

// File: rtl/wsg_wait_ctr.sv
// Module: wait counter and wait-output sequencer.
// In the request cycle the wait output is formed from the effective count and
// ready; the counter then holds the remaining cycles. The counter register
// only updates while its clock enable is high. Assumes requests are one-cycle
// strobes and that requests during a busy cycle are to be ignored.
module wsg_wait_ctr #(
    parameter int C_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic [C_W-1:0] eff_cnt,
    input  logic           ready,
    input  logic           any_nonzero,
    output logic           bus_wait,
    output logic           cnt_en
);
    logic           busy;
    logic [C_W-1:0] cnt;
    logic           cnt_nz;
    logic           start;

    assign cnt_nz = (cnt != '0);
    assign cnt_en = any_nonzero || cnt_nz;
    assign start  = !busy && req && bus_wait;

    // Wait output: request cycle uses the new count, later cycles the counter.
    always_comb begin
        if (busy) begin
            bus_wait = cnt_nz || !ready;
        end else begin
            bus_wait = req && ((eff_cnt != '0) || !ready);
        end
    end

    // Busy flag: set when an access needs waits, cleared when count and ready allow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (busy) begin
            if (!cnt_nz && ready) begin
                busy <= 1'b0;
            end
        end else if (start) begin
            busy <= 1'b1;
        end
    end

    // Counter: preload remaining waits on start, count down while busy, gated by enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_en) begin
            if (busy) begin
                if (cnt_nz) begin
                    cnt <= cnt - 1'b1;
                end
            end else if (start) begin
                cnt <= (eff_cnt == '0) ? '0 : eff_cnt - 1'b1;
            end
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cnt_nz |=> cnt == $past(cnt) - 1'b1); // R6
    AST_END_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cnt_nz && ready |=> !busy); // R7
    AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cnt_nz && !ready |=> busy); // R7
    AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req && cnt_nz |=> cnt == $past(cnt) - 1'b1); // R10
    AST_GATED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt)); // R11
endmodule

// File: rtl/bus_wait_gen.sv
// Module: top of the programmable bus wait-state generator.
// Connects the register block, the region classifier and the wait counter.
// Assumes the bus master holds space and address valid with the request strobe.
module bus_wait_gen
    import wsg_pkg::*;
#(
    parameter int A_W    = ADDR_W,
    localparam int REG_W = NUM_RGN * BASE_W + 1,
    localparam int EFF_W = BASE_W + 1,
    localparam int MAX_EFF = 2 * ((1 << BASE_W) - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             acc_req,
    input  logic [1:0]       acc_space,
    input  logic [A_W-1:0]   acc_addr,
    input  logic             acc_ready,
    output logic             bus_wait,
    output logic             cnt_clk_en
);
    logic [REG_W-1:0] cfg_q;
    logic             mul_q;
    region_e          rgn;
    logic [EFF_W-1:0] eff_cnt;
    logic             any_nonzero;

    wsg_cfg_regs #(
        .N_RGN (NUM_RGN),
        .FLD_W (BASE_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q),
        .mul_q (mul_q)
    );

    wsg_region_map #(
        .A_W   (A_W),
        .N_RGN (NUM_RGN),
        .FLD_W (BASE_W)
    ) u_map (
        .space       (acc_space),
        .addr        (acc_addr),
        .cfg         (cfg_q),
        .mul         (mul_q),
        .rgn         (rgn),
        .eff_cnt     (eff_cnt),
        .any_nonzero (any_nonzero)
    );

    wsg_wait_ctr #(
        .C_W (EFF_W)
    ) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (acc_req),
        .eff_cnt     (eff_cnt),
        .ready       (acc_ready),
        .any_nonzero (any_nonzero),
        .bus_wait    (bus_wait),
        .cnt_en      (cnt_clk_en)
    );

    AST_EFF_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |-> eff_cnt <= EFF_W'(MAX_EFF)); // R3
    AST_IO_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_space[1] |-> rgn == RG_IO); // R4
    AST_ZERO_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !any_nonzero && acc_ready && !bus_wait |=> !bus_wait || acc_req); // R8
endmodule

// File: tb/bus_wait_gen_bench.sv
module bus_wait_gen_bench;
    localparam int PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        cfg_wr;
    logic        cfg_sel;
    logic [15:0] cfg_wdata;
    logic        acc_req;
    logic [1:0]  acc_space;
    logic [22:0] acc_addr;
    logic        acc_ready;
    logic        bus_wait;
    logic        cnt_clk_en;

    int n_checks = 0;
    int n_err    = 0;

    bus_wait_gen u_bus_wait_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .acc_req    (acc_req),
        .acc_space  (acc_space),
        .acc_addr   (acc_addr),
        .acc_ready  (acc_ready),
        .bus_wait   (bus_wait),
        .cnt_clk_en (cnt_clk_en)
    );

    initial begin
        clk = 1'b0;
        forever #(PERIOD/2) clk = ~clk;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [15:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // One access; returns the number of cycles with bus_wait high.
    task automatic access(input logic [1:0] sp, input logic [22:0] ad,
                          input int l_rdy, input int re_at,
                          input logic [1:0] re_sp, input logic [22:0] re_ad,
                          input int wr_at, input logic [15:0] wr_val,
                          output int waits);
        int k;
        waits = 0;
        k = 0;
        @(negedge clk);
        acc_req = 1'b1; acc_space = sp; acc_addr = ad;
        acc_ready = (l_rdy > 0) ? 1'b0 : 1'b1;
        while (k < 60) begin
            #(PERIOD/4);
            if (!bus_wait) break;
            waits++;
            @(negedge clk);
            k++;
            acc_req = (k == re_at);
            if (k == re_at) begin
                acc_space = re_sp; acc_addr = re_ad;
            end
            acc_ready = (k < l_rdy) ? 1'b0 : 1'b1;
            cfg_wr = (k == wr_at); cfg_sel = 1'b0; cfg_wdata = wr_val;
        end
        @(negedge clk);
        acc_req = 1'b0; cfg_wr = 1'b0; acc_ready = 1'b1;
    endtask

    task automatic simple(input logic [1:0] sp, input logic [22:0] ad,
                          input int l_rdy, output int waits);
        access(sp, ad, l_rdy, -1, 2'b00, 23'h0, -1, 16'h0, waits);
    endtask

    function automatic int fld(input int b, input int r);
        return (b + r) % 8;
    endfunction

    function automatic logic [1:0] rg_space(input int r, input int b);
        case (r)
            0, 1:    return 2'b00;
            2, 3:    return 2'b01;
            default: return (b % 2 == 1) ? 2'b11 : 2'b10;
        endcase
    endfunction

    function automatic logic [22:0] rg_addr(input int r);
        case (r)
            0:       return 23'h000123;
            1:       return 23'h00C123;
            2:       return 23'h401000;
            3:       return 23'h00F000;
            default: return 23'h7FABCD;
        endcase
    endfunction

    initial begin
        int w;
        logic [15:0] cv;
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        acc_req = 1'b0; acc_space = '0; acc_addr = '0; acc_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(PERIOD/4);
        check("R11 reset clock enable", int'(cnt_clk_en), 1);
        check("R1 reset idle wait", int'(bus_wait), 0);

        // R1: every region gives 7 waits after reset
        for (int r = 0; r < 5; r++) begin
            simple(rg_space(r, 0), rg_addr(r), 0, w);
            check($sformatf("R1 reset region %0d", r), w, 7);
        end

        // R2 R3 R4 R6: sweep base values, multiplier and regions
        for (int m = 0; m < 2; m++) begin
            reg_write(1'b1, 16'(m));
            for (int b = 0; b < 8; b++) begin
                cv = '0;
                for (int r = 0; r < 5; r++) cv |= 16'(fld(b, r)) << (3 * r);
                reg_write(1'b0, cv);
                for (int r = 0; r < 5; r++) begin
                    simple(rg_space(r, b), rg_addr(r), 0, w);
                    check($sformatf("R2 R3 R4 R6 m=%0d b=%0d region %0d", m, b, r),
                          w, fld(b, r) * (m + 1));
                end
            end
        end
        reg_write(1'b1, 16'h0);

        // R5: extended-address select changes the upper program decision
        reg_write(1'b0, 16'h0031);
        simple(2'b00, 23'h008000, 0, w); check("R5 xsel0 bit15 high", w, 6);
        simple(2'b00, 23'h400000, 0, w); check("R5 xsel0 bit22 only", w, 1);
        reg_write(1'b0, 16'h8031);
        simple(2'b00, 23'h008000, 0, w); check("R5 xsel1 bit15 only", w, 1);
        simple(2'b00, 23'h400000, 0, w); check("R5 xsel1 bit22 high", w, 6);
        simple(2'b00, 23'h7FFFFF, 0, w); check("R5 xsel1 top address", w, 6);

        // R7: ready extension gives max(N, L)
        reg_write(1'b0, 16'h0003);
        simple(2'b00, 23'h000010, 6, w); check("R7 N=3 L=6", w, 6);
        reg_write(1'b0, 16'h0005);
        simple(2'b00, 23'h000010, 2, w); check("R7 N=5 L=2", w, 5);
        simple(2'b00, 23'h000010, 5, w); check("R7 N=5 L=5", w, 5);

        // R10: request during a busy cycle is ignored
        reg_write(1'b0, 16'h0005 << 6 | 16'h0001);
        access(2'b01, 23'h001000, 0, 2, 2'b00, 23'h000000, -1, 16'h0, w);
        check("R10 reissue ignored length", w, 5);
        #(PERIOD/4);
        check("R10 idle after reissue", int'(bus_wait), 0);

        // R9: configuration write mid-access leaves loaded count intact
        reg_write(1'b0, 16'h5000);
        access(2'b10, 23'h000000, 0, -1, 2'b00, 23'h0, 2, 16'h0000, w);
        check("R9 count kept after write", w, 5);
        #(PERIOD/4);
        check("R11 gated when all zero", int'(cnt_clk_en), 0);

        // R8: zero count with ready high gives no wait
        simple(2'b10, 23'h000000, 0, w); check("R8 zero count no wait", w, 0);
        simple(2'b01, 23'h00F000, 0, w); check("R8 zero count data", w, 0);
        simple(2'b01, 23'h00F000, 4, w); check("R7 zero count ready low", w, 4);
        #(PERIOD/4);
        check("R11 gated after ready extension", int'(cnt_clk_en), 0);

        reg_write(1'b0, 16'h0200);
        #(PERIOD/4);
        check("R11 enabled with one field", int'(cnt_clk_en), 1);
        simple(2'b01, 23'h00F000, 0, w); check("R9 next request uses new count", w, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule